// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Automatic Same-Page Demap

This block caches virtual-to-physical page translations for all hardware strands of one core. Every resident entry is compared with the incoming virtual page number in parallel. An entry can describe one of four page sizes, and a larger page ignores more low-order bits of the page number. A lookup presents a virtual page number. One cycle later the block answers with a hit flag, the page-size code of the matching entry and the physical page number. For a large page, the low bits of that page number are taken from the request.

Software or a table walker loads translations through the install port. When the new translation has the same page size as a resident entry and covers the same page, the old entry is dropped and the new one takes over its slot. Two entries can therefore never match one address at the same size. Otherwise the new translation goes to the lowest-numbered empty slot. When the table is full, a round-robin victim pointer chooses the slot. A flush input empties the whole table in one cycle.

Slot choice for an install is a three-way decision: PICK_DEMAP reuses the slot of a same-page, same-size entry, PICK_FREE takes the lowest empty slot, and PICK_VICTIM takes the slot under the round-robin pointer. PICK_DEMAP has priority over PICK_FREE, which has priority over PICK_VICTIM. The only stored sequencing state is the victim pointer. It steps from its current slot to the next one, wrapping from the last slot to slot 0, and it moves only when PICK_VICTIM is taken.

Top module: `xlat_tlb`

## Requirements
- R1: When `lk_req` is high at a clock edge, `rsp_vld` is high for exactly the next cycle together with that lookup's result. The result reflects the table as it stood before any install or flush taking effect at the same edge. Without `lk_req`, `rsp_vld` and `rsp_hit` are low.
- R2: An entry with size code s (0 to 3) matches when its VPN and the lookup VPN agree in every bit except the lowest 4*s bits. Code 0 compares all 28 bits.
- R3: On a hit, `rsp_ppn` is the entry's PPN with its lowest 4*s bits replaced by the same bits of `lk_vpn`, and `rsp_sz` is the entry's size code. On a miss, `rsp_ppn` and `rsp_sz` are zero.
- R4: An install whose size code equals that of a valid entry, and whose VPN agrees with it above the lowest 4*s bits, overwrites that entry's slot. Afterwards only the new translation answers, and neither a free slot nor the victim pointer is used.
- R5: Entries with different size codes are never demapped against each other. When several entries match one lookup, the lowest-numbered slot answers.
- R6: An install that demaps nothing goes into the lowest-numbered invalid slot.
- R7: When every slot is valid and nothing is demapped, the install replaces the slot under the victim pointer. The pointer is 0 after reset, advances by one after each such replacement, wraps from the last slot to 0, and keeps its value across a flush.
- R8: `flush_all` invalidates every entry at the next edge. An install in the same cycle is dropped.
- R9: After reset, every entry is invalid and `rsp_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 28 | Virtual page number to translate |
| rsp_vld | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 24 | Translated physical page number |
| rsp_sz | output | 2 | Page-size code of the matching entry |
| ins_req | input | 1 | Install request |
| ins_vpn | input | 28 | VPN of the new translation |
| ins_sz | input | 2 | Page-size code of the new translation |
| ins_ppn | input | 24 | PPN of the new translation |
| flush_all | input | 1 | Invalidate every entry |

## Verification
Lookups are tried with exact addresses, addresses that differ only inside a page's offset bits, and addresses that differ just above it, for size codes 0, 2 and 3. This separates per-entry masking from a fixed mask and shows where the low PPN bits come from. Installs are tried in three cases: the same page and size, the same page with another size, and the same cycle as a lookup or a flush. These cases show whether a slot is reused, kept or dropped. Fill, eviction and wrap sequences are run from a fresh reset and after a flush that leaves the victim pointer away from 0. They distinguish first-free placement from pointer placement and show that demap reuse consumes no pointer step.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VPN_W    = 28;
    localparam int PPN_W    = 24;
    localparam int SZ_W     = 2;
    localparam int SZ_SHIFT = 4;

    typedef logic [SZ_W-1:0] pgsz_t;

    typedef enum logic [1:0] {
        PICK_DEMAP  = 2'd0,
        PICK_FREE   = 2'd1,
        PICK_VICTIM = 2'd2
    } pick_t;

    // Bits of the page number that take part in the compare for size s.
    function automatic logic [VPN_W-1:0] keep_mask(input pgsz_t s);
        return {VPN_W{1'b1}} << (SZ_SHIFT * int'(s));
    endfunction

    // Low PPN bits that come from the request address for size s.
    function automatic logic [PPN_W-1:0] off_mask(input pgsz_t s);
        return ~({PPN_W{1'b1}} << (SZ_SHIFT * int'(s)));
    endfunction
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int N        = 64,
    parameter bit EXACT_SZ = 1'b0
) (
    input  logic [N-1:0]            vld,
    input  pgsz_t [N-1:0]           sz,
    input  logic [N-1:0][VPN_W-1:0] vpn,
    input  logic [VPN_W-1:0]        key_vpn,
    input  pgsz_t                   key_sz,
    output logic [N-1:0]            match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic size_ok;
        logic page_ok;
        assign size_ok  = !EXACT_SZ || (sz[g] == key_sz);
        assign page_ok  = ((vpn[g] ^ key_vpn) & keep_mask(sz[g])) == '0;
        assign match[g] = vld[g] && size_ok && page_ok;
    end
endmodule

// File: rtl/xlat_first_one.sv
module xlat_first_one #(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [27:0]      lk_vpn,
    output logic             rsp_vld,
    output logic             rsp_hit,
    output logic [23:0]      rsp_ppn,
    output logic [1:0]       rsp_sz,
    input  logic             ins_req,
    input  logic [27:0]      ins_vpn,
    input  logic [1:0]       ins_sz,
    input  logic [23:0]      ins_ppn,
    input  logic             flush_all
);
    localparam int IW = $clog2(ENTRIES);
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    logic [ENTRIES-1:0]            vld_q;
    pgsz_t [ENTRIES-1:0]           sz_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
    logic [IW-1:0]                 rr_q;

    logic [ENTRIES-1:0] lk_match, dm_match;
    logic               lk_found, dm_found, free_found;
    logic [IW-1:0]      lk_idx, dm_idx, free_idx;
    pick_t              pick;
    logic [IW-1:0]      slot;
    logic               do_ins;

    // Size-aware lookup compare: each entry masks by its own size.
    xlat_cam #(.N(ENTRIES), .EXACT_SZ(1'b0)) u_lk_cam (
        .vld(vld_q), .sz(sz_q), .vpn(vpn_q),
        .key_vpn(lk_vpn), .key_sz(2'b00), .match(lk_match)
    );

    // Same-page, same-size compare for automatic demap on install.
    xlat_cam #(.N(ENTRIES), .EXACT_SZ(1'b1)) u_dm_cam (
        .vld(vld_q), .sz(sz_q), .vpn(vpn_q),
        .key_vpn(ins_vpn), .key_sz(ins_sz), .match(dm_match)
    );

    xlat_first_one #(.N(ENTRIES)) u_lk_pri (
        .vec(lk_match), .found(lk_found), .idx(lk_idx)
    );
    xlat_first_one #(.N(ENTRIES)) u_dm_pri (
        .vec(dm_match), .found(dm_found), .idx(dm_idx)
    );
    xlat_first_one #(.N(ENTRIES)) u_free_pri (
        .vec(~vld_q), .found(free_found), .idx(free_idx)
    );

    // Install slot selection: demap reuse, then first free, then victim.
    always_comb begin
        if (dm_found)        pick = PICK_DEMAP;
        else if (free_found) pick = PICK_FREE;
        else                 pick = PICK_VICTIM;
    end

    always_comb begin
        unique case (pick)
            PICK_DEMAP:  slot = dm_idx;
            PICK_FREE:   slot = free_idx;
            PICK_VICTIM: slot = rr_q;
            default:     slot = rr_q;
        endcase
    end

    assign do_ins = ins_req && !flush_all;

    // Table contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (flush_all) begin
            vld_q <= '0;
        end else if (do_ins) begin
            vld_q[slot] <= 1'b1;
            sz_q[slot]  <= ins_sz;
            vpn_q[slot] <= ins_vpn;
            ppn_q[slot] <= ins_ppn;
        end
    end

    // Round-robin victim pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (do_ins && pick == PICK_VICTIM) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld <= 1'b0;
            rsp_hit <= 1'b0;
            rsp_ppn <= '0;
            rsp_sz  <= '0;
        end else begin
            rsp_vld <= lk_req;
            rsp_hit <= lk_req && lk_found;
            if (lk_req && lk_found) begin
                rsp_ppn <= (ppn_q[lk_idx] & ~off_mask(sz_q[lk_idx]))
                         | (lk_vpn[PPN_W-1:0] & off_mask(sz_q[lk_idx]));
                rsp_sz  <= sz_q[lk_idx];
            end else begin
                rsp_ppn <= '0;
                rsp_sz  <= '0;
            end
        end
    end

    // ---------------- assertions ----------------
    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_vld);
    p_no_rsp_without_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_vld && !rsp_hit));
    p_miss_is_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_hit) |-> (rsp_ppn == '0 && rsp_sz == '0));
    p_no_duplicate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dm_match));
    p_install_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_ins |=> vld_q[$past(slot)]);
    p_fill_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ins && pick == PICK_FREE) |=> ($countones(vld_q) == $past($countones(vld_q)) + 1));
    p_victim_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ins && pick == PICK_VICTIM) |=> (rr_q != $past(rr_q)));
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld_q == '0));
endmodule

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [27:0] lk_vpn = '0;
    logic        rsp_vld, rsp_hit;
    logic [23:0] rsp_ppn;
    logic [1:0]  rsp_sz;
    logic        ins_req = 1'b0;
    logic [27:0] ins_vpn = '0;
    logic [1:0]  ins_sz = '0;
    logic [23:0] ins_ppn = '0;
    logic        flush_all = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xlat_tlb uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_sz(rsp_sz),
        .ins_req(ins_req), .ins_vpn(ins_vpn), .ins_sz(ins_sz), .ins_ppn(ins_ppn),
        .flush_all(flush_all)
    );

    function automatic logic [23:0] xlate(input logic [23:0] ppn, input logic [27:0] va,
                                          input logic [1:0] s);
        logic [23:0] m;
        m = ~(24'hFFFFFF << (4 * int'(s)));
        return (ppn & ~m) | (va[23:0] & m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic install(input logic [27:0] v, input logic [1:0] s, input logic [23:0] p);
        ins_req = 1'b1; ins_vpn = v; ins_sz = s; ins_ppn = p;
        @(negedge clk);
        ins_req = 1'b0;
    endtask

    // Lookup, then compare {vld,hit,sz,ppn} one cycle later.
    task automatic lookup(input string req, input logic [27:0] v, input logic hit,
                          input logic [23:0] p, input logic [1:0] s);
        lk_req = 1'b1; lk_vpn = v;
        @(negedge clk);
        lk_req = 1'b0;
        check(req, {4'h0, rsp_vld, rsp_hit, rsp_sz, rsp_ppn},
                   {4'h0, 1'b1, hit, hit ? s : 2'b00, hit ? p : 24'h0});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 rsp_vld in reset", {31'h0, rsp_vld}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 rsp_vld idle", {31'h0, rsp_vld}, 32'h0);
        lookup("R9 empty table miss", 28'h0000000, 1'b0, 24'h0, 2'b00);
        @(negedge clk);
        check("R1 no response without request", {30'h0, rsp_vld, rsp_hit}, 32'h0);
    endtask

    task automatic t_sizes;
        install(28'h0123450, 2'd0, 24'hABC001);
        install(28'h0456700, 2'd2, 24'h777000);
        install(28'h1230000, 2'd3, 24'h555000);
        lookup("R2 exact size0 hit", 28'h0123450, 1'b1, 24'hABC001, 2'd0);
        lookup("R2 size0 low bit differs", 28'h0123451, 1'b0, 24'h0, 2'd0);
        lookup("R3 size2 offset merge", 28'h045675A, 1'b1,
               xlate(24'h777000, 28'h045675A, 2'd2), 2'd2);
        lookup("R2 size2 bit above offset", 28'h0456600, 1'b0, 24'h0, 2'd0);
        lookup("R3 size3 offset merge", 28'h1230ABC, 1'b1, 24'h555ABC, 2'd3);
    endtask

    task automatic t_same_cycle;
        ins_req = 1'b1; ins_vpn = 28'h0999990; ins_sz = 2'd0; ins_ppn = 24'h000001;
        lookup("R1 lookup sees pre-install state", 28'h0999990, 1'b0, 24'h0, 2'd0);
        ins_req = 1'b0;
        lookup("R1 install visible next cycle", 28'h0999990, 1'b1, 24'h000001, 2'd0);
    endtask

    task automatic t_demap;
        install(28'h0123450, 2'd0, 24'h0000AA);
        lookup("R4 demap replaces size0", 28'h0123450, 1'b1, 24'h0000AA, 2'd0);
        install(28'h0333330, 2'd1, 24'h100000);
        install(28'h0333337, 2'd1, 24'h200000);
        lookup("R4 same page size1 replaced", 28'h0333332, 1'b1, 24'h200002, 2'd1);
        install(28'h0333330, 2'd0, 24'h300000);
        lookup("R5 other size kept", 28'h0333332, 1'b1, 24'h200002, 2'd1);
        lookup("R5 lowest slot wins", 28'h0333330, 1'b1, 24'h200000, 2'd1);
    endtask

    task automatic t_flush;
        flush_all = 1'b1;
        install(28'h0777770, 2'd0, 24'h000077);
        flush_all = 1'b0;
        lookup("R8 flush cleared entry", 28'h0123450, 1'b0, 24'h0, 2'd0);
        lookup("R8 install during flush dropped", 28'h0777770, 1'b0, 24'h0, 2'd0);
        lookup("R8 size3 entry cleared", 28'h1230000, 1'b0, 24'h0, 2'd0);
    endtask

    task automatic t_fill_victim;
        for (int i = 0; i < 64; i++) install(28'h1000000 + 28'(i), 2'd0, 24'(i));
        lookup("R6 fill last slot", 28'h100003F, 1'b1, 24'h00003F, 2'd0);
        install(28'h2000000, 2'd0, 24'h0A0000);
        lookup("R7 first victim slot0", 28'h1000000, 1'b0, 24'h0, 2'd0);
        lookup("R7 slot1 still present", 28'h1000001, 1'b1, 24'h000001, 2'd0);
        install(28'h2000001, 2'd0, 24'h0A0001);
        lookup("R7 pointer advanced to slot1", 28'h1000001, 1'b0, 24'h0, 2'd0);
        install(28'h1000005, 2'd0, 24'h000DDD);
        lookup("R4 demap in full table", 28'h1000005, 1'b1, 24'h000DDD, 2'd0);
        lookup("R4 demap spent no victim", 28'h1000002, 1'b1, 24'h000002, 2'd0);
        install(28'h2000002, 2'd0, 24'h0A0002);
        lookup("R7 next victim slot2", 28'h1000002, 1'b0, 24'h0, 2'd0);
        lookup("R7 slot3 still present", 28'h1000003, 1'b1, 24'h000003, 2'd0);
        for (int j = 0; j < 61; j++) install(28'h3000000 + 28'(j), 2'd0, 24'h0B0000 + 24'(j));
        install(28'h4000000, 2'd0, 24'h0C0000);
        lookup("R7 wrap evicts slot0", 28'h2000000, 1'b0, 24'h0, 2'd0);
        lookup("R7 wrap keeps slot1", 28'h2000001, 1'b1, 24'h0A0001, 2'd0);
    endtask

    task automatic t_free_after_flush;
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        for (int i = 0; i < 64; i++) install(28'h5000000 + 28'(i), 2'd0, 24'h0D0000 + 24'(i));
        install(28'h6000000, 2'd0, 24'h0E0000);
        lookup("R6 free-first then R7 pointer kept", 28'h5000001, 1'b0, 24'h0, 2'd0);
        lookup("R6 slot0 kept", 28'h5000000, 1'b1, 24'h0D0000, 2'd0);
        lookup("R6 slot2 kept", 28'h5000002, 1'b1, 24'h0D0002, 2'd0);
        lookup("R7 new entry present", 28'h6000000, 1'b1, 24'h0E0000, 2'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sizes();
        t_same_cycle();
        t_demap();
        t_flush();
        t_fill_victim();
        t_free_after_flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule